// File: doc/BRIEF.md
# Drawing Command Packet Framer

This block sits on the data port of a drawing unit. It takes a stream of 32-bit words and cuts it into whole command packets. The first word of each packet carries the opcode in bits [31:24]. For most opcodes, a per-opcode extra-word count fixes the packet length. Two families of line-strip opcodes have no fixed length. They run until a vertex word that matches a sentinel pattern. One family tests every word for the sentinel, and the other tests only every second word.

Each framed word is sent downstream one cycle after it is accepted. Start-of-packet and end-of-packet flags mark the first and last word. Opcodes 0xE0-0xE7 load one of eight environment registers, and the low thirteen bits of the status word are rebuilt from two of those registers. Image-transfer opcodes do not go to the packet output. Their position and size words are collected and passed to a transfer engine with a one-cycle start pulse. While the engine reports an image write in progress, incoming words go straight to it and skip framing. A command-reset pulse drops any partly received packet.

Top module: `cmd_framer`

## Requirements
- R1: After reset, environment register i (bits [32*i+31:32*i] of `env_bus`) reads (0xE0+i)<<24, `status_lo` reads 0, and `pkt_valid`, `xfer_start` and `xfer_wvalid` are low.
- R2: A fixed-length packet is 1 + extra words long. The extra count per opcode is:
  - 0x02: 2
  - 0x20-23: 3
  - 0x24-27: 6
  - 0x28-2B: 4
  - 0x2C-2F: 8
  - 0x30-33: 5
  - 0x34-37: 8
  - 0x38-3B: 7
  - 0x3C-3F: 11
  - 0x40-47: 2
  - 0x50-57: 3
  - 0x60-63: 2
  - 0x64-67: 3
  - 0x68-6B: 1
  - 0x70-73: 1
  - 0x74-77: 2
  - 0x78-7B: 1
  - 0x7C-7F: 2
  - 0x80: 3
- R3: Any other opcode outside the line-strip and image ranges gives a one-word packet with `pkt_sop` and `pkt_eop` both set.
- R4: For opcodes 0x48-0x4F the packet ends at the first word, at index 3 or later, with (w & 0xF000F000) == 0x50005000. A matching word at index 1 or 2 does not end the packet.
- R5: For opcodes 0x58-0x5F the packet ends at the first matching word at an even index of 4 or more. A matching word at an odd index does not end the packet.
- R6: An opcode word with bits [31:27] = 11100 stores the whole word in environment register [26:24]. It is also emitted as a one-word packet.
- R7: `status_lo[10:0]` equals environment register 1 bits [10:0], and `status_lo[12:11]` equals environment register 6 bits [1:0].
- R8: Opcodes 0xA0-0xDF form 3-word image commands that never appear on the packet output. One cycle after the third word is accepted, `xfer_start` pulses for one cycle with `xfer_pos` = word 1 and `xfer_size` = word 2. `xfer_read` is set when opcode bits [7:5] = 110.
- R9: While `xfer_wr_busy` is high, each accepted word appears on `xfer_wdata` with `xfer_wvalid` one cycle later. Such words do not reach the packet output and do not change the framing state.
- R10: During a `cmd_reset` cycle `in_ready` is low. Any partial packet is dropped, so the next word accepted is framed as an opcode.
- R11: A framed word appears on `pkt_data` with `pkt_valid` exactly one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_reset | input | 1 | Drops any partial packet |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word can be accepted |
| xfer_wr_busy | input | 1 | Transfer engine is receiving image-write data |
| pkt_valid | output | 1 | Framed word valid |
| pkt_sop | output | 1 | First word of a packet |
| pkt_eop | output | 1 | Last word of a packet |
| pkt_data | output | 32 | Framed word |
| env_bus | output | 256 | Eight environment registers, register i in bits [32*i+31:32*i] |
| status_lo | output | 13 | Low status bits built from the environment registers |
| xfer_start | output | 1 | One-cycle start of an image transfer |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wvalid | output | 1 | Bypassed image-write word valid |
| xfer_wdata | output | 32 | Bypassed image-write word |

## Verification
Random opcode bytes drawn over the whole 0-255 range exercise the length lookup. Each one produces a packet whose length the stimulus generator knows, so any error in a table entry shows up as a wrong end marker.

Line-strip packets are built with decoy sentinel words:
- For the stride-1 family, decoys sit before index 3.
- For the stride-2 family, decoys sit at odd indices.

These decoys separate a correct terminator search from one that matches too early or ignores the stride.

Directed sequences check the remaining paths:
- environment writes that show up in the status bits;
- image reads and writes with their direction flag;
- bypass words that look like opcodes;
- a command reset in the middle of a packet.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  localparam int WORD_W  = 32;
  localparam int OP_W    = 8;
  localparam int NUM_ENV = 8;
  localparam int ENV_SEL_W = $clog2(NUM_ENV);
  localparam logic [31:0] SENT_MASK  = 32'hF000_F000;
  localparam logic [31:0] SENT_MATCH = 32'h5000_5000;

  function automatic logic [3:0] extra_words(input logic [OP_W-1:0] op);
    logic [3:0] n;
    n = 4'd0;
    if (op == 8'h02)            n = 4'd2;
    else if (op[7:5] == 3'b001) begin
      case (op[4:2])
        3'd0: n = 4'd3;  3'd1: n = 4'd6;  3'd2: n = 4'd4;  3'd3: n = 4'd8;
        3'd4: n = 4'd5;  3'd5: n = 4'd8;  3'd6: n = 4'd7;  default: n = 4'd11;
      endcase
    end
    else if (op[7:3] == 5'b01000) n = 4'd2;
    else if (op[7:3] == 5'b01010) n = 4'd3;
    else if (op[7:4] == 4'h6) begin
      case (op[3:2])
        2'd0: n = 4'd2;  2'd1: n = 4'd3;  2'd2: n = 4'd1;  default: n = 4'd0;
      endcase
    end
    else if (op[7:4] == 4'h7) n = op[2] ? 4'd2 : 4'd1;
    else if (op == 8'h80)       n = 4'd3;
    return n;
  endfunction

  function automatic logic is_strip1(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b01001;
  endfunction

  function automatic logic is_strip2(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b01011;
  endfunction

  function automatic logic is_image(input logic [OP_W-1:0] op);
    return (op >= 8'hA0) && (op <= 8'hDF);
  endfunction

  function automatic logic is_env(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b11100;
  endfunction

  function automatic logic is_sentinel(input logic [WORD_W-1:0] w);
    return (w & SENT_MASK) == SENT_MATCH;
  endfunction

  function automatic logic [WORD_W-1:0] env_reset_value(input int i);
    return WORD_W'((32'hE0 + i) << 24);
  endfunction

endpackage

// File: rtl/cf_framer.sv
module cf_framer
  import cmd_framer_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_reset,
  input  logic                 fire,
  input  logic [WORD_W-1:0]    word,
  output logic                 pkt_valid,
  output logic                 pkt_sop,
  output logic                 pkt_eop,
  output logic [WORD_W-1:0]    pkt_data,
  output logic                 env_we,
  output logic [ENV_SEL_W-1:0] env_sel,
  output logic                 img_pos_we,
  output logic                 img_size_we,
  output logic                 img_read
);

  logic             busy_q, ph_q;
  logic [OP_W-1:0]  op_q;
  logic [IDX_W-1:0] idx_q;

  logic             first, cur_ph, img, last;
  logic [OP_W-1:0]  cur_op;
  logic [IDX_W-1:0] cur_idx;

  always_comb begin
    first   = !busy_q;
    cur_op  = first ? word[31:24] : op_q;
    cur_idx = first ? '0 : idx_q;
    cur_ph  = first ? 1'b0 : ph_q;
    img     = is_image(cur_op);
    if (img)
      last = (cur_idx == IDX_W'(2));
    else if (is_strip1(cur_op))
      last = (cur_idx >= IDX_W'(3)) && is_sentinel(word);
    else if (is_strip2(cur_op))
      last = (cur_idx >= IDX_W'(4)) && !cur_ph && is_sentinel(word);
    else
      last = (cur_idx == IDX_W'(extra_words(cur_op)));
    env_we      = fire && first && is_env(cur_op);
    env_sel     = cur_op[ENV_SEL_W-1:0];
    img_pos_we  = fire && img && (cur_idx == IDX_W'(1));
    img_size_we = fire && img && (cur_idx == IDX_W'(2));
    img_read    = (cur_op[7:5] == 3'b110);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ph_q <= 1'b0; op_q <= '0; idx_q <= '0;
      pkt_valid <= 1'b0; pkt_sop <= 1'b0; pkt_eop <= 1'b0; pkt_data <= '0;
    end else if (cmd_reset) begin
      busy_q <= 1'b0; pkt_valid <= 1'b0; pkt_sop <= 1'b0; pkt_eop <= 1'b0;
    end else begin
      pkt_valid <= fire && !img;
      pkt_sop   <= fire && !img && first;
      pkt_eop   <= fire && !img && last;
      if (fire) begin
        pkt_data <= word;
        busy_q   <= !last;
        op_q     <= cur_op;
        idx_q    <= (&cur_idx) ? cur_idx : cur_idx + IDX_W'(1);
        ph_q     <= ~cur_ph;
      end
    end
  end

  // R3: an environment opcode is a complete one-word packet
  a_r3_env_single: assert property (@(posedge clk) disable iff (!rst_n)
    env_we && !cmd_reset |=> pkt_valid && pkt_sop && pkt_eop);
  // R8: image words never reach the packet output
  a_r8_image_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (img_pos_we || img_size_we) |=> !pkt_valid);
  // R10: command reset leaves the framer idle
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !busy_q);
  // R11: framed words appear one cycle after acceptance
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cmd_reset && !img |=> pkt_valid && pkt_data == $past(word));
  // R4: a stride-1 strip closes only on a sentinel word
  a_r4_strip_close: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cmd_reset && is_strip1(cur_op) && !first && !is_sentinel(word) |=> !pkt_eop);

endmodule

// File: rtl/cf_env_bank.sv
module cf_env_bank
  import cmd_framer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ENV_SEL_W-1:0]      sel,
  input  logic [WORD_W-1:0]         word,
  output logic [NUM_ENV*WORD_W-1:0] env_bus,
  output logic [12:0]               status_lo
);

  logic [WORD_W-1:0] env_q [NUM_ENV];

  for (genvar i = 0; i < NUM_ENV; i++) begin : g_env
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        env_q[i] <= env_reset_value(i);
      else if (we && sel == ENV_SEL_W'(i))
        env_q[i] <= word;
    end
    assign env_bus[i*WORD_W +: WORD_W] = env_q[i];

    // R6: the selected register takes the whole word
    a_r6_env_store: assert property (@(posedge clk) disable iff (!rst_n)
      we && sel == ENV_SEL_W'(i) |=> env_bus[i*WORD_W +: WORD_W] == $past(word));
  end

  assign status_lo = {env_q[6][1:0], env_q[1][10:0]};

  // R7: status low bits follow a write to register 1
  a_r7_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
    we && sel == ENV_SEL_W'(1) |=> status_lo[10:0] == $past(word[10:0]));

endmodule

// File: rtl/cf_xfer.sv
module cf_xfer
  import cmd_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pos_we,
  input  logic              size_we,
  input  logic              read_in,
  input  logic              byp_fire,
  input  logic [WORD_W-1:0] word,
  output logic              xfer_start,
  output logic              xfer_read,
  output logic [WORD_W-1:0] xfer_pos,
  output logic [WORD_W-1:0] xfer_size,
  output logic              xfer_wvalid,
  output logic [WORD_W-1:0] xfer_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_start <= 1'b0; xfer_read <= 1'b0; xfer_pos <= '0; xfer_size <= '0;
      xfer_wvalid <= 1'b0; xfer_wdata <= '0;
    end else begin
      xfer_start  <= size_we;
      xfer_wvalid <= byp_fire;
      if (byp_fire) xfer_wdata <= word;
      if (pos_we)   xfer_pos   <= word;
      if (size_we) begin
        xfer_size <= word;
        xfer_read <= read_in;
      end
    end
  end

  // R8: start is a single-cycle pulse
  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  // R9: a bypassed word is forwarded and starts nothing
  a_r9_bypass_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    byp_fire |=> xfer_wvalid && !xfer_start && xfer_wdata == $past(word));

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_reset,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_data,
  output logic                      in_ready,
  input  logic                      xfer_wr_busy,
  output logic                      pkt_valid,
  output logic                      pkt_sop,
  output logic                      pkt_eop,
  output logic [WORD_W-1:0]         pkt_data,
  output logic [NUM_ENV*WORD_W-1:0] env_bus,
  output logic [12:0]               status_lo,
  output logic                      xfer_start,
  output logic                      xfer_read,
  output logic [WORD_W-1:0]         xfer_pos,
  output logic [WORD_W-1:0]         xfer_size,
  output logic                      xfer_wvalid,
  output logic [WORD_W-1:0]         xfer_wdata
);

  logic fire, frame_fire, byp_fire;
  logic env_we, img_pos_we, img_size_we, img_read;
  logic [ENV_SEL_W-1:0] env_sel;

  assign in_ready   = !cmd_reset;
  assign fire       = in_valid && in_ready;
  assign byp_fire   = fire && xfer_wr_busy;
  assign frame_fire = fire && !xfer_wr_busy;

  cf_framer #(.IDX_W(IDX_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .fire(frame_fire), .word(in_data),
    .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_data(pkt_data),
    .env_we(env_we), .env_sel(env_sel), .img_pos_we(img_pos_we),
    .img_size_we(img_size_we), .img_read(img_read)
  );

  cf_env_bank u_env (
    .clk(clk), .rst_n(rst_n), .we(env_we), .sel(env_sel), .word(in_data),
    .env_bus(env_bus), .status_lo(status_lo)
  );

  cf_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .pos_we(img_pos_we), .size_we(img_size_we),
    .read_in(img_read), .byp_fire(byp_fire), .word(in_data),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_wvalid(xfer_wvalid), .xfer_wdata(xfer_wdata)
  );

  // R10: no word is taken while a command reset is applied
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !pkt_valid && !xfer_wvalid);

endmodule

// File: tb/cmd_framer_test.sv
module cmd_framer_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cmd_reset = 1'b0, in_valid = 1'b0, xfer_wr_busy = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, pkt_valid, pkt_sop, pkt_eop, xfer_start, xfer_read, xfer_wvalid;
  logic [31:0] pkt_data, xfer_pos, xfer_size, xfer_wdata;
  logic [255:0] env_bus;
  logic [12:0] status_lo;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] benv [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_framer uut (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .xfer_wr_busy(xfer_wr_busy), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .pkt_data(pkt_data), .env_bus(env_bus), .status_lo(status_lo),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .xfer_wvalid(xfer_wvalid), .xfer_wdata(xfer_wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // total words of a fixed-length packet (R2, R3)
  function automatic int ref_len(input logic [7:0] op);
    case (op) inside
      8'h02: return 3;
      [8'h20:8'h23]: return 4;   [8'h24:8'h27]: return 7;
      [8'h28:8'h2B]: return 5;   [8'h2C:8'h2F]: return 9;
      [8'h30:8'h33]: return 6;   [8'h34:8'h37]: return 9;
      [8'h38:8'h3B]: return 8;   [8'h3C:8'h3F]: return 12;
      [8'h40:8'h47]: return 3;   [8'h50:8'h57]: return 4;
      [8'h60:8'h63]: return 3;   [8'h64:8'h67]: return 4;
      [8'h68:8'h6B]: return 2;   [8'h70:8'h73]: return 2;
      [8'h74:8'h77]: return 3;   [8'h78:8'h7B]: return 2;
      [8'h7C:8'h7F]: return 3;   8'h80: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] plain();
    return $urandom & 32'h0FFF_FFFF;
  endfunction

  function automatic logic [31:0] sent();
    return 32'h5000_5000 | ($urandom & 32'h0FFF_0FFF);
  endfunction

  // R11: drive one word, check the framed output one cycle later
  task automatic send(input logic [31:0] w, input bit ev, input bit es, input bit ee, input string tag);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 32'(pkt_valid), 32'(ev));
    if (ev) begin
      check({tag, " sop"}, 32'(pkt_sop), 32'(es));
      check({tag, " eop"}, 32'(pkt_eop), 32'(ee));
      check({tag, " data"}, pkt_data, w);
    end
  endtask

  task automatic check_env(input string tag);
    for (int i = 0; i < 8; i++) check({tag, " R6 env"}, env_bus[i*32 +: 32], benv[i]);
    check({tag, " R7 status"}, 32'(status_lo), 32'({benv[6][1:0], benv[1][10:0]}));
  endtask

  task automatic image_cmd(input logic [7:0] op);
    logic [31:0] p, s;
    p = $urandom; s = $urandom;
    send({op, 24'h0}, 0, 0, 0, "R8 img op");
    check("R8 no start early", 32'(xfer_start), 0);
    send(p, 0, 0, 0, "R8 img pos");
    send(s, 0, 0, 0, "R8 img size");
    check("R8 start", 32'(xfer_start), 1);
    check("R8 pos", xfer_pos, p);
    check("R8 size", xfer_size, s);
    check("R8 dir", 32'(xfer_read), 32'(op[7:5] == 3'b110));
    @(negedge clk);
    check("R8 pulse ends", 32'(xfer_start), 0);
  endtask

  task automatic gen_pkt(input logic [7:0] op);
    int n, k;
    if (op >= 8'hA0 && op <= 8'hDF) image_cmd(op);
    else if (op[7:3] == 5'b01001) begin
      k = int'($urandom % 4);
      send({op, plain()[23:0]}, 1, 1, 0, "R4 strip1 op");
      send(sent(), 1, 0, 0, "R4 early marker ignored");
      send(plain(), 1, 0, 0, "R4 body");
      for (int j = 0; j < k; j++) send(plain(), 1, 0, 0, "R4 body");
      send(sent(), 1, 0, 1, "R4 end");
    end else if (op[7:3] == 5'b01011) begin
      k = int'($urandom % 3);
      send({op, plain()[23:0]}, 1, 1, 0, "R5 strip2 op");
      for (int j = 0; j < 3; j++) send(plain(), 1, 0, 0, "R5 body");
      for (int j = 0; j < k; j++) begin
        send(plain(), 1, 0, 0, "R5 even body");
        send(sent(), 1, 0, 0, "R5 odd marker ignored");
      end
      send(sent(), 1, 0, 1, "R5 end");
    end else begin
      n = ref_len(op);
      for (int i = 0; i < n; i++) begin
        logic [31:0] w;
        w = (i == 0) ? {op, 24'($urandom)} : plain();
        send(w, 1, i == 0, i == n - 1, (n == 1) ? "R3 single" : "R2 fixed");
        if (i == 0 && op[7:3] == 5'b11100) begin
          benv[op[2:0]] = w;
          check_env("R6 write");
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    for (int i = 0; i < 8; i++) benv[i] = (32'hE0 + i) << 24;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_env("R1 reset");
    check("R1 pkt_valid", 32'(pkt_valid), 0);
    check("R1 xfer_start", 32'(xfer_start), 0);
    check("R1 xfer_wvalid", 32'(xfer_wvalid), 0);

    // directed corners
    send(32'h4800_0000, 1, 1, 0, "R4 op");
    send(32'h5000_5000, 1, 0, 0, "R4 idx1 marker");
    send(32'h5123_5456, 1, 0, 0, "R4 idx2 marker");
    send(32'h5FFF_5FFF, 1, 0, 1, "R4 idx3 marker ends");
    send(32'h5800_0000, 1, 1, 0, "R5 op");
    for (int j = 0; j < 3; j++) send(32'h0000_0001, 1, 0, 0, "R5 body");
    send(32'h5000_5000, 1, 0, 1, "R5 idx4 ends");
    gen_pkt(8'hE1); gen_pkt(8'hE6); gen_pkt(8'hE3);
    image_cmd(8'hC0); image_cmd(8'hA5); image_cmd(8'hDF);
    gen_pkt(8'h3C); gen_pkt(8'h80); gen_pkt(8'h02);

    // R9 bypass: opcode-like words go to the engine
    xfer_wr_busy = 1'b1;
    for (int j = 0; j < 3; j++) begin
      logic [31:0] w;
      w = 32'h2C00_0000 | 32'($urandom & 32'hFFFF);
      send(w, 0, 0, 0, "R9 bypass no pkt");
      check("R9 wvalid", 32'(xfer_wvalid), 1);
      check("R9 wdata", xfer_wdata, w);
    end
    xfer_wr_busy = 1'b0;
    send(32'h0000_0000, 1, 1, 1, "R9 framing untouched");

    // R10 command reset mid-packet
    send(32'h3800_0000, 1, 1, 0, "R10 partial op");
    send(32'h0000_1111, 1, 0, 0, "R10 partial body");
    cmd_reset = 1'b1; in_valid = 1'b1; in_data = 32'h0000_2222;
    #1 check("R10 in_ready low", 32'(in_ready), 0);
    @(negedge clk);
    cmd_reset = 1'b0; in_valid = 1'b0;
    check("R10 word dropped", 32'(pkt_valid), 0);
    send(32'h0300_0000, 1, 1, 1, "R10 next is opcode");
    check_env("R10 env kept");

    // random opcode stream
    for (int p = 0; p < 400; p++) gen_pkt(8'($urandom));
    check_env("R7 final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule